// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block is the processor-facing side of an asynchronous serial controller. A host reaches it over an 8-bit bidirectional bus qualified by two chip selects, one active high and one active low. Two select lines pick a register and a direction line tells reads from writes. The block holds the control and line-format registers, assembles the status byte, raises an active-low interrupt request, and divides the system clock down to a sampling tick at sixteen times the chosen bit rate.

The shift logic for transmit and receive sits outside. The receiver hands over each finished byte with a one-cycle strobe and two error flags. The transmitter signals with a one-cycle pulse when it has taken the pending byte. Several control-register fields act on each other: the receive interrupt is enabled by a zero. A single two-bit field selects transmit interrupt, line break, or neither. Echo mode is honoured only while that two-bit field is clear.

Every rising clock edge at which both chip selects are active counts as one complete bus access. The reset pin is sampled on the clock.

Top module: `sc_host_regs`

## Requirements
- R1: An access occurs on each rising clock edge with `cs_hi_i`=1 and `cs_lo_n_i`=0. The register is chosen by `rs_i`: 0 is receive data on read and transmit data on write, 1 is status (read only), 2 is control, 3 is format. During a read (`rw_i`=1) the block drives `data_io` with the selected register; otherwise `data_io` is high impedance. Control and format read back the last value written.
- R2: A clock edge with `rst_n_i`=0 clears the control and format registers to 0x00. Status then reads 0x10 when both modem inputs are high. `irq_n_o` is 1 and `dtr_o` is 0.
- R3: Status bit positions are: bit0 parity error, bit1 framing error, bit2 overrun, bit3 receive full, bit4 transmit empty, bit5 carrier detect active (`dcd_n_i` low), bit6 data-set-ready active (`dsr_n_i` low), bit7 interrupt occurred.
- R4: An `rx_stb_i` pulse while the receive register is not full loads `rx_data_i` and sets bit3. It also ORs `rx_perr_i` into bit0 and `rx_ferr_i` into bit1. A read of register 0 returns the byte and clears bit3.
- R5: An `rx_stb_i` pulse while bit3 is set, with no data read in that cycle, keeps the held byte and sets bit2.
- R6: A status read returns the current value. It then clears bits 0, 1, 2 and 7, except where a set event occurs in the same cycle.
- R7: A write to register 0 places the byte on `tx_data_o` and clears bit4. A `tx_take_i` pulse sets bit4.
- R8: With control bit1 = 0, each byte load into the receive register sets bit7. With control bit1 = 1 a byte load leaves bit7 unchanged. `irq_n_o` is low exactly while bit7 is set.
- R9: A `tx_take_i` pulse that sets bit4 also sets bit7 only when control bits [3:2] = 01.
- R10: `brk_o` is 1 exactly when control bits [3:2] = 11.
- R11: `echo_o` is 1 exactly when control bit4 = 1 and control bits [3:2] = 00.
- R12: `dtr_o` follows control bit0.
- R13: With format bit4 = 1 and a rate code in format bits [3:0] of 0110, 0111, 1000, 1010, 1011, 1100 or 1110 (300, 600, 1200, 2400, 3600, 4800, 9600 baud), `baud_tick_o` gives one-cycle pulses every round(CLK_HZ/(16*rate)) cycles. With format bit4 = 0 or any other code there are no pulses. A format write restarts the count.
- R14: `par_cfg_o` carries control bits [7:5] and `frame_cfg_o` carries format bits [7:5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| cs_hi_i | input | 1 | Chip select, active high |
| cs_lo_n_i | input | 1 | Chip select, active low |
| rs_i | input | 2 | Register select |
| rw_i | input | 1 | 1 = read, 0 = write |
| data_io | inout | 8 | Bidirectional host data bus |
| irq_n_o | output | 1 | Interrupt request, active low |
| dtr_o | output | 1 | Terminal-ready line level |
| rx_data_i | input | 8 | Byte from the receive shifter |
| rx_stb_i | input | 1 | One-cycle pulse: received byte valid |
| rx_perr_i | input | 1 | Parity error for the strobed byte |
| rx_ferr_i | input | 1 | Framing error for the strobed byte |
| tx_data_o | output | 8 | Byte for the transmit shifter |
| tx_take_i | input | 1 | One-cycle pulse: transmitter took the byte |
| dcd_n_i | input | 1 | Carrier detect, active low |
| dsr_n_i | input | 1 | Data set ready, active low |
| brk_o | output | 1 | Hold the transmit line in break |
| echo_o | output | 1 | Receiver echo mode active |
| par_cfg_o | output | 3 | Parity configuration field |
| frame_cfg_o | output | 3 | Word length and stop-bit field |
| baud_tick_o | output | 1 | Sampling tick at 16x bit rate |

## Verification
The bench builds the block with the default `CLK_HZ` of 1,843,200. At that clock every listed rate divides exactly, with tick periods from 12 cycles at 9600 baud up to 384 cycles at 300 baud. This lets the bench measure the spacing of the slowest and fastest ticks within a few hundred cycles and compare each one against a divisor it computes itself. The clock also keeps the stopped cases (external clock selected, or an unlisted code) quick to observe over a window longer than any valid period.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_FMT  = 2'd3
    } sel_e;

    // status byte, MSB first
    typedef struct packed {
        logic irq;
        logic dsr;
        logic dcd;
        logic tx_empty;
        logic rx_full;
        logic overrun;
        logic frm_err;
        logic par_err;
    } stat_t;

    typedef struct packed {
        logic [2:0] par;
        logic       echo;
        logic [1:0] txc;
        logic       rx_irq_off;
        logic       dtr;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] frame;
        logic       int_clk;
        logic [3:0] rate;
    } fmt_t;

    localparam logic [1:0] TXC_IRQ = 2'b01;
    localparam logic [1:0] TXC_BRK = 2'b11;

    function automatic int unsigned baud_of(logic [3:0] code);
        case (code)
            4'b0110: return 300;
            4'b0111: return 600;
            4'b1000: return 1200;
            4'b1010: return 2400;
            4'b1011: return 3600;
            4'b1100: return 4800;
            4'b1110: return 9600;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned div_of(int unsigned clk_hz, logic [3:0] code);
        int unsigned r;
        r = baud_of(code);
        if (r == 0) return 0;
        return (clk_hz + 8 * r) / (16 * r);
    endfunction

endpackage

// File: rtl/sc_cfg_regs.sv
module sc_cfg_regs
    import sc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_fmt_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output fmt_t              fmt_o,
    output logic              rx_irq_en_o,
    output logic              tx_irq_en_o,
    output logic              brk_o,
    output logic              echo_o
);

    ctrl_t ctrl_q;
    fmt_t  fmt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ctrl_q <= '0;
            fmt_q  <= '0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i);
            if (wr_fmt_i)  fmt_q  <= fmt_t'(wdata_i);
        end
    end

    always_comb begin
        rx_irq_en_o = ~ctrl_q.rx_irq_off;
        tx_irq_en_o = (ctrl_q.txc == TXC_IRQ);
        brk_o       = (ctrl_q.txc == TXC_BRK);
        echo_o      = ctrl_q.echo & (ctrl_q.txc == 2'b00);
    end

    assign ctrl_o = ctrl_q;
    assign fmt_o  = fmt_q;

    a_r1_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_ctrl_i |=> (ctrl_o == ctrl_t'($past(wdata_i))));

    a_r1_fmt_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_fmt_i |=> (fmt_o == fmt_t'($past(wdata_i))));

endmodule

// File: rtl/sc_line_status.sv
module sc_line_status
    import sc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              rd_data_i,
    input  logic              wr_data_i,
    input  logic              rd_stat_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_stb_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              tx_take_i,
    input  logic              dcd_n_i,
    input  logic              dsr_n_i,
    input  logic              rx_irq_en_i,
    input  logic              tx_irq_en_i,
    output stat_t             stat_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic [DATA_W-1:0] tx_byte_o
);

    logic rx_full_q, tx_empty_q, perr_q, ferr_q, ovr_q, irq_q;
    logic [DATA_W-1:0] rx_byte_q, tx_byte_q;

    logic hold_full, rx_load, rx_ovr, tx_done;

    always_comb begin
        hold_full = rx_full_q & ~rd_data_i;
        rx_load   = rx_stb_i & ~hold_full;
        rx_ovr    = rx_stb_i & hold_full;
        tx_done   = tx_take_i & ~tx_empty_q & ~wr_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rx_full_q  <= 1'b0;
            tx_empty_q <= 1'b1;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            ovr_q      <= 1'b0;
            irq_q      <= 1'b0;
            rx_byte_q  <= '0;
            tx_byte_q  <= '0;
        end else begin
            rx_full_q <= hold_full | rx_stb_i;
            if (rx_load) rx_byte_q <= rx_data_i;
            if (wr_data_i) begin
                tx_empty_q <= 1'b0;
                tx_byte_q  <= wdata_i;
            end else if (tx_take_i) begin
                tx_empty_q <= 1'b1;
            end
            perr_q <= (perr_q & ~rd_stat_i) | (rx_load & rx_perr_i);
            ferr_q <= (ferr_q & ~rd_stat_i) | (rx_load & rx_ferr_i);
            ovr_q  <= (ovr_q  & ~rd_stat_i) | rx_ovr;
            irq_q  <= (irq_q  & ~rd_stat_i)
                    | (rx_load & rx_irq_en_i)
                    | (tx_done & tx_irq_en_i);
        end
    end

    always_comb begin
        stat_o.irq      = irq_q;
        stat_o.dsr      = ~dsr_n_i;
        stat_o.dcd      = ~dcd_n_i;
        stat_o.tx_empty = tx_empty_q;
        stat_o.rx_full  = rx_full_q;
        stat_o.overrun  = ovr_q;
        stat_o.frm_err  = ferr_q;
        stat_o.par_err  = perr_q;
    end

    assign rx_byte_o = rx_byte_q;
    assign tx_byte_o = tx_byte_q;

    a_r4_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_data_i && !rx_stb_i) |=> !stat_o.rx_full);

    a_r5_overrun_keeps_byte: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rx_stb_i && stat_o.rx_full && !rd_data_i)
            |=> (stat_o.overrun && rx_byte_o == $past(rx_byte_o)));

    a_r6_status_read_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_stat_i && !rx_stb_i && !(tx_take_i && tx_irq_en_i)) |=> !stat_o.irq);

    a_r7_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_data_i |=> !stat_o.tx_empty);

    a_r9_tx_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (tx_take_i && !stat_o.tx_empty && !wr_data_i && tx_irq_en_i) |=> stat_o.irq);

endmodule

// File: rtl/sc_tick_gen.sv
module sc_tick_gen
    import sc_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_843_200
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       restart_i,
    input  logic       int_clk_i,
    input  logic [3:0] rate_i,
    output logic       tick_o
);

    localparam int unsigned DIV_MAX = div_of(CLK_HZ, 4'b0110);
    localparam int unsigned DIV_MIN = div_of(CLK_HZ, 4'b1110);
    localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);
    localparam int unsigned N_CODES = 16;

    logic [CNT_W-1:0] div_tab [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_div
        assign div_tab[g] = CNT_W'(div_of(CLK_HZ, 4'(g)));
    end

    logic [CNT_W-1:0] div_cur, cnt_q;
    logic             run, tick_q;

    always_comb begin
        div_cur = div_tab[rate_i];
        run     = int_clk_i & (div_cur != '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || restart_i || !run) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == div_cur - CNT_W'(1)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    a_r13_quiet_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !run |=> !tick_o);

    if (DIV_MIN > 1) begin : g_pulse_chk
        a_r13_single_cycle_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            tick_o |=> !tick_o);
    end

endmodule

// File: rtl/sc_host_regs.sv
module sc_host_regs
    import sc_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_843_200
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n_i,
    input  logic [1:0]        rs_i,
    input  logic              rw_i,
    inout  wire  [DATA_W-1:0] data_io,
    output logic              irq_n_o,
    output logic              dtr_o,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_stb_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_take_i,
    input  logic              dcd_n_i,
    input  logic              dsr_n_i,
    output logic              brk_o,
    output logic              echo_o,
    output logic [2:0]        par_cfg_o,
    output logic [2:0]        frame_cfg_o,
    output logic              baud_tick_o
);

    logic        sel, rd_en, wr_en;
    sel_e        reg_sel;
    logic        rd_data, wr_data, rd_stat, wr_ctrl, wr_fmt;
    logic [DATA_W-1:0] wdata, rd_val;

    ctrl_t ctrl;
    fmt_t  fmt;
    stat_t stat;
    logic  rx_irq_en, tx_irq_en;
    logic [DATA_W-1:0] rx_byte;

    always_comb begin
        sel     = cs_hi_i & ~cs_lo_n_i;
        rd_en   = sel & rw_i;
        wr_en   = sel & ~rw_i;
        reg_sel = sel_e'(rs_i);
        rd_data = rd_en & (reg_sel == SEL_DATA);
        rd_stat = rd_en & (reg_sel == SEL_STAT);
        wr_data = wr_en & (reg_sel == SEL_DATA);
        wr_ctrl = wr_en & (reg_sel == SEL_CTRL);
        wr_fmt  = wr_en & (reg_sel == SEL_FMT);
    end

    assign wdata = data_io;

    sc_cfg_regs u_cfg (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .wr_ctrl_i   (wr_ctrl),
        .wr_fmt_i    (wr_fmt),
        .wdata_i     (wdata),
        .ctrl_o      (ctrl),
        .fmt_o       (fmt),
        .rx_irq_en_o (rx_irq_en),
        .tx_irq_en_o (tx_irq_en),
        .brk_o       (brk_o),
        .echo_o      (echo_o)
    );

    sc_line_status u_stat (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .rd_data_i   (rd_data),
        .wr_data_i   (wr_data),
        .rd_stat_i   (rd_stat),
        .wdata_i     (wdata),
        .rx_data_i   (rx_data_i),
        .rx_stb_i    (rx_stb_i),
        .rx_perr_i   (rx_perr_i),
        .rx_ferr_i   (rx_ferr_i),
        .tx_take_i   (tx_take_i),
        .dcd_n_i     (dcd_n_i),
        .dsr_n_i     (dsr_n_i),
        .rx_irq_en_i (rx_irq_en),
        .tx_irq_en_i (tx_irq_en),
        .stat_o      (stat),
        .rx_byte_o   (rx_byte),
        .tx_byte_o   (tx_data_o)
    );

    sc_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .restart_i (wr_fmt),
        .int_clk_i (fmt.int_clk),
        .rate_i    (fmt.rate),
        .tick_o    (baud_tick_o)
    );

    always_comb begin
        case (reg_sel)
            SEL_DATA: rd_val = rx_byte;
            SEL_STAT: rd_val = stat;
            SEL_CTRL: rd_val = ctrl;
            default:  rd_val = fmt;
        endcase
    end

    assign data_io     = rd_en ? rd_val : {DATA_W{1'bz}};
    assign irq_n_o     = ~stat.irq;
    assign dtr_o       = ctrl.dtr;
    assign par_cfg_o   = ctrl.par;
    assign frame_cfg_o = fmt.frame;

endmodule

// File: tb/test_sc_host_regs.sv
`timescale 1ns/1ps
module test_sc_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_hi = 1'b0, cs_lo_n = 1'b1, rw = 1'b1;
    logic [1:0] rs = 2'd0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_drv = 8'h00;
    wire  [7:0] bus;
    logic       irq_n, dtr, brk, echo, tick;
    logic [7:0] rx_data = 8'h00, tx_data;
    logic       rx_stb = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, tx_take = 1'b0;
    logic       dcd_n = 1'b1, dsr_n = 1'b1;
    logic [2:0] par_cfg, frame_cfg;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit done = 0;

    assign bus = tb_oe ? tb_drv : 8'bz;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sc_host_regs i_sc_host_regs (
        .clk_i(clk), .rst_n_i(rst_n), .cs_hi_i(cs_hi), .cs_lo_n_i(cs_lo_n),
        .rs_i(rs), .rw_i(rw), .data_io(bus), .irq_n_o(irq_n), .dtr_o(dtr),
        .rx_data_i(rx_data), .rx_stb_i(rx_stb), .rx_perr_i(rx_perr),
        .rx_ferr_i(rx_ferr), .tx_data_o(tx_data), .tx_take_i(tx_take),
        .dcd_n_i(dcd_n), .dsr_n_i(dsr_n), .brk_o(brk), .echo_o(echo),
        .par_cfg_o(par_cfg), .frame_cfg_o(frame_cfg), .baud_tick_o(tick)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] sel, logic [7:0] val);
        @(negedge clk);
        cs_hi = 1; cs_lo_n = 0; rw = 0; rs = sel; tb_drv = val; tb_oe = 1;
        @(negedge clk);
        cs_hi = 0; cs_lo_n = 1; rw = 1; tb_oe = 0;
    endtask

    task automatic bus_rd(logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        cs_hi = 1; cs_lo_n = 0; rw = 1; rs = sel; tb_oe = 0;
        #3 val = bus;
        @(negedge clk);
        cs_hi = 0; cs_lo_n = 1;
    endtask

    task automatic rx_push(logic [7:0] b, logic pe, logic fe);
        @(negedge clk);
        rx_data = b; rx_perr = pe; rx_ferr = fe; rx_stb = 1;
        @(negedge clk);
        rx_stb = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic take_pulse();
        @(negedge clk); tx_take = 1;
        @(negedge clk); tx_take = 0;
    endtask

    function automatic int exp_div(logic [4:0] f);
        int r;
        if (!f[4]) return 0;
        case (f[3:0])
            4'd6: r = 300;   4'd7: r = 600;   4'd8: r = 1200;
            4'd10: r = 2400; 4'd11: r = 3600; 4'd12: r = 4800;
            4'd14: r = 9600; default: r = 0;
        endcase
        if (r == 0) return 0;
        return (1843200 + 8 * r) / (16 * r);
    endfunction

    function automatic bit exp_brk(logic [7:0] c);  return c[3:2] == 2'b11; endfunction
    function automatic bit exp_echo(logic [7:0] c); return c[4] && c[3:2] == 2'b00; endfunction

    // period between two ticks, 0 if none seen within the window
    task automatic tick_period(output int p);
        int first;
        p = 0; first = -1;
        for (int i = 0; i < 900; i++) begin
            @(negedge clk);
            if (tick) begin
                if (first < 0) first = cyc;
                else begin p = cyc - first; break; end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int p;
        void'($urandom(32'h0005_eed1));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R2 reset state
        chk("R2 irq_n", irq_n, 1);
        chk("R2 dtr", dtr, 0);
        chk("R1 bus idle Z", (bus === 8'bz), 1);
        bus_rd(2'd1, v); chk("R2 status", v, 8'h10);
        bus_rd(2'd2, v); chk("R2 ctrl", v, 8'h00);
        bus_rd(2'd3, v); chk("R2 fmt", v, 8'h00);

        // R1 / R14 register write and readback
        bus_wr(2'd2, 8'hE1); bus_rd(2'd2, v); chk("R1 ctrl readback", v, 8'hE1);
        chk("R14 par_cfg", par_cfg, 3'b111); chk("R12 dtr", dtr, 1);
        bus_wr(2'd3, 8'hA0); bus_rd(2'd3, v); chk("R1 fmt readback", v, 8'hA0);
        chk("R14 frame_cfg", frame_cfg, 3'b101);

        // R3 modem inputs
        dcd_n = 0; #1; bus_rd(2'd1, v); chk("R3 dcd bit5", v, 8'h30);
        dcd_n = 1; dsr_n = 0; #1; bus_rd(2'd1, v); chk("R3 dsr bit6", v, 8'h50);
        dsr_n = 1;

        // R4 R8 receive with parity error, rx irq enabled
        bus_wr(2'd2, 8'h00);
        rx_push(8'hA5, 1, 0); #1;
        chk("R8 irq_n low", irq_n, 0);
        bus_rd(2'd1, v); chk("R4 status after load", v, 8'h99);
        bus_rd(2'd1, v); chk("R6 status cleared", v, 8'h18);
        chk("R8 irq_n released", irq_n, 1);
        bus_rd(2'd0, v); chk("R4 rx data", v, 8'hA5);
        bus_rd(2'd1, v); chk("R4 full cleared", v, 8'h10);

        // R5 overrun
        rx_push(8'h11, 0, 1); rx_push(8'h22, 0, 0);
        bus_rd(2'd1, v); chk("R5 overrun status", v, 8'h9E);
        bus_rd(2'd1, v); chk("R6 errors cleared", v, 8'h18);
        bus_rd(2'd0, v); chk("R5 old byte kept", v, 8'h11);

        // R8 rx irq disabled
        bus_wr(2'd2, 8'h02);
        rx_push(8'h55, 0, 0); #1;
        chk("R8 no irq when off", irq_n, 1);
        bus_rd(2'd1, v); chk("R8 status no D7", v, 8'h18);
        bus_rd(2'd0, v); chk("R4 rx data 2", v, 8'h55);

        // R7 R9 transmit
        bus_wr(2'd2, 8'h04);
        bus_wr(2'd0, 8'h3C); #1;
        chk("R7 tx_data", tx_data, 8'h3C);
        bus_rd(2'd1, v); chk("R7 empty cleared", v, 8'h00);
        take_pulse(); #1;
        chk("R9 irq_n on take", irq_n, 0);
        bus_rd(2'd1, v); chk("R9 status", v, 8'h90);
        chk("R10 no break", brk, 0);
        bus_wr(2'd2, 8'h0C); #1;
        chk("R10 break on", brk, 1);
        bus_wr(2'd0, 8'hC3); take_pulse(); #1;
        chk("R9 no irq with 11", irq_n, 1);
        bus_rd(2'd1, v); chk("R9 status no D7", v, 8'h10);
        bus_wr(2'd2, 8'h08); #1; chk("R10 break off", brk, 0);
        bus_wr(2'd0, 8'h77); take_pulse(); #1;
        chk("R9 no irq with 10", irq_n, 1);

        // R11 echo
        bus_wr(2'd2, 8'h10); #1; chk("R11 echo on", echo, 1);
        bus_wr(2'd2, 8'h14); #1; chk("R11 echo gated", echo, 0);

        // R13 baud tick
        bus_wr(2'd3, 8'h1E); tick_period(p); chk("R13 9600 period", p, 12);
        bus_wr(2'd3, 8'h16); tick_period(p); chk("R13 300 period", p, 384);
        bus_wr(2'd3, 8'h1B); tick_period(p); chk("R13 3600 period", p, 32);
        bus_wr(2'd3, 8'h0E); tick_period(p); chk("R13 external stops", p, 0);
        bus_wr(2'd3, 8'h19); tick_period(p); chk("R13 unlisted stops", p, 0);

        // random control values
        for (int i = 0; i < 20; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            bus_wr(2'd2, c); #1;
            chk("R10 rand brk", brk, exp_brk(c));
            chk("R11 rand echo", echo, exp_echo(c));
            chk("R12 rand dtr", dtr, c[0]);
            chk("R14 rand par", par_cfg, c[7:5]);
            bus_rd(2'd2, v); chk("R1 rand ctrl", v, c);
        end

        // random received bytes
        bus_wr(2'd2, 8'h00);
        bus_rd(2'd1, v);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b; logic pe, fe;
            b = 8'($urandom); pe = 1'($urandom); fe = 1'($urandom);
            rx_push(b, pe, fe);
            bus_rd(2'd1, v);
            chk("R4 rand status", v, 8'h98 | {6'b0, fe, pe});
            bus_rd(2'd0, v); chk("R4 rand data", v, b);
        end

        // random format values
        for (int i = 0; i < 4; i++) begin
            logic [7:0] f;
            f = 8'($urandom) | 8'h10;
            bus_wr(2'd3, f);
            bus_rd(2'd3, v); chk("R1 rand fmt", v, f);
            tick_period(p); chk("R13 rand period", p, exp_div(f[4:0]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule